// File: doc/BRIEF.md
# Adaptive Vote Loop Filter for a Digital CDR

This block is the loop filter and phase state of a first-order digital clock and data recovery loop. A phase detector upstream sends it one early or late pulse per decision. The block keeps a signed vote that sums these pulses. When the vote magnitude goes past the current decision threshold, the block moves its sampling phase register by one programmable step and clears the vote. The phase interpolator downstream reads the resulting phase as an unsigned fraction of one symbol. A value of 256 counts equals one symbol, and the value wraps modulo one symbol.

Lock is faster because the threshold does not start at its final value. It begins at 2 and grows by one on every phase step until it reaches a programmable ceiling. A two-state machine follows this ramp. In state ACQUIRE the threshold is still growing. The transition ACQUIRE->TRACK is taken on the clock edge after the threshold reaches its ceiling, and the block then reports lock. The transition TRACK->ACQUIRE is taken only on a restart or a reset. A static offset is added to the tracked phase, so the sampling point can be placed away from the tracked centre of the eye. A one-cycle step pulse, with its direction, reports every phase move.

Top module: `cdr_vote_loop`

## Requirements
- R1: An early pulse adds 1 to the signed vote and a late pulse subtracts 1. When the updated vote is greater than the threshold, or less than minus the threshold, a phase step happens on that edge and the vote returns to 0. The vote magnitude never exceeds the threshold.
- R2: A step caused by early pulses raises the phase by `cfg_step` counts. A step caused by late pulses lowers it by `cfg_step` counts. The phase wraps modulo 256 counts, so 2 counts is 1/128 symbol and 4 counts is 1/64 symbol.
- R3: A cycle in which early and late are both high leaves the vote unchanged and causes no step.
- R4: The threshold is 2 after reset or restart. It rises by 1 on each step until it equals the effective ceiling. The effective ceiling is `cfg_max_thr`, but a value below 2 is treated as 2.
- R5: `locked` (1 = state TRACK) rises one cycle after the threshold reaches the effective ceiling. It is 0 in state ACQUIRE.
- R6: `phase_out` equals the tracked phase plus `cfg_offset`, modulo 256. It follows a change of `cfg_offset` in the same cycle.
- R7: `step_evt` is high for exactly the one cycle after each step edge. During that cycle `step_dir` is 1 for an upward step and 0 for a downward step.
- R8: A cycle with `restart` high clears the vote, sets the threshold to 2 and returns the state to ACQUIRE, which clears `locked`. It causes no step and keeps the tracked phase.
- R9: While `rst_n` is low, the tracked phase and the vote are 0, the threshold is 2, `locked` is 0 and `step_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decision clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Restart acquisition (vote, threshold and state) and keep the phase |
| early | input | 1 | Early pulse from the phase detector |
| late | input | 1 | Late pulse from the phase detector |
| cfg_step | input | PH_W | Phase step in 1/256-symbol counts |
| cfg_max_thr | input | THR_W | Threshold ceiling (values below 2 act as 2) |
| cfg_offset | input | PH_W | Static offset added to the output phase |
| phase_out | output | PH_W | Sampling phase, tracked phase plus offset |
| step_evt | output | 1 | One-cycle pulse after each phase step |
| step_dir | output | 1 | Direction of the last step, 1 = up |
| locked | output | 1 | Threshold ramp complete (state TRACK) |

## Verification
A wrong vote or threshold cannot be seen directly at the ports. It shows up as a step pulse that comes one or more pulses too early or too late. The vectors are therefore chosen so that the first wrong count moves the step by at least one cycle, and the expected step is checked in the exact cycle after the deciding pulse. A wrong phase register or a wrong step direction shows up in `phase_out` on the cycle right after the step, including across the wrap at 256. A wrong state shows up in `locked` one cycle after the threshold reaches its ceiling.

// File: rtl/cdr_vote_pkg.sv
package cdr_vote_pkg;

    // Acquisition state: threshold ramping, or threshold at its ceiling.
    typedef enum logic [0:0] {
        ST_ACQUIRE = 1'b0,
        ST_TRACK   = 1'b1
    } loop_state_e;

    // Threshold value after reset or restart.
    localparam int unsigned THR_START = 2;

endpackage

// File: rtl/cdr_vote_acc.sv
module cdr_vote_acc #(
    parameter int unsigned THR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    early,
    input  logic                    late,
    input  logic [THR_W-1:0]        thr,
    output logic                    step_up,
    output logic                    step_dn,
    output logic signed [THR_W:0]   vote_q
);

    // Stored vote holds +-thr. The sum before the compare needs one bit more.
    localparam int unsigned VW = THR_W + 1;
    localparam int unsigned SW = VW + 1;

    logic signed [SW-1:0] vote_ext;
    logic signed [SW-1:0] vote_next;
    logic signed [SW-1:0] thr_pos;
    logic signed [SW-1:0] thr_neg;
    logic                 only_early;
    logic                 only_late;

    always_comb begin
        only_early = early && !late;
        only_late  = late && !early;
        vote_ext   = $signed({vote_q[VW-1], vote_q});
        thr_pos    = $signed({2'b00, thr});
        thr_neg    = -thr_pos;
        if (only_early) begin
            vote_next = vote_ext + $signed(SW'(1));
        end else if (only_late) begin
            vote_next = vote_ext - $signed(SW'(1));
        end else begin
            vote_next = vote_ext;
        end
        step_up = !restart && (vote_next > thr_pos);
        step_dn = !restart && (vote_next < thr_neg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_q <= '0;
        end else if (restart || step_up || step_dn) begin
            vote_q <= '0;
        end else begin
            vote_q <= $signed(vote_next[VW-1:0]);
        end
    end

endmodule

// File: rtl/cdr_thr_ctrl.sv
module cdr_thr_ctrl
    import cdr_vote_pkg::*;
#(
    parameter int unsigned THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [THR_W-1:0] cfg_max_thr,
    output logic [THR_W-1:0] thr_q,
    output logic             locked
);

    localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_START);

    loop_state_e      state_q;
    loop_state_e      state_d;
    logic [THR_W-1:0] ceil_eff;
    logic             at_ceil;

    always_comb begin
        ceil_eff = (cfg_max_thr < THR_INIT) ? THR_INIT : cfg_max_thr;
        at_ceil  = (thr_q >= ceil_eff);
    end

    // Threshold ramp: grows by one on every step while below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_INIT;
        end else if (restart) begin
            thr_q <= THR_INIT;
        end else if (step && !at_ceil) begin
            thr_q <= thr_q + THR_W'(1);
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: if (!restart && at_ceil) state_d = ST_TRACK;
            ST_TRACK:   if (restart)             state_d = ST_ACQUIRE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_ACQUIRE: locked = 1'b0;
            ST_TRACK:   locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/cdr_phase_acc.sv
module cdr_phase_acc #(
    parameter int unsigned PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_up,
    input  logic            step_dn,
    input  logic [PH_W-1:0] cfg_step,
    input  logic [PH_W-1:0] cfg_offset,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_out,
    output logic            step_evt,
    output logic            step_dir
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            step_evt <= 1'b0;
            step_dir <= 1'b0;
        end else begin
            step_evt <= step_up || step_dn;
            if (step_up) begin
                phase_q  <= phase_q + cfg_step;
                step_dir <= 1'b1;
            end else if (step_dn) begin
                phase_q  <= phase_q - cfg_step;
                step_dir <= 1'b0;
            end
        end
    end

    // Modulo-one-symbol sum of tracked phase and static offset.
    always_comb begin
        phase_out = phase_q + cfg_offset;
    end

endmodule

// File: rtl/cdr_vote_loop.sv
module cdr_vote_loop #(
    parameter int unsigned PH_W  = 8,
    parameter int unsigned THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             early,
    input  logic             late,
    input  logic [PH_W-1:0]  cfg_step,
    input  logic [THR_W-1:0] cfg_max_thr,
    input  logic [PH_W-1:0]  cfg_offset,
    output logic [PH_W-1:0]  phase_out,
    output logic             step_evt,
    output logic             step_dir,
    output logic             locked
);

    logic                  step_up;
    logic                  step_dn;
    logic [THR_W-1:0]      thr_q;
    logic signed [THR_W:0] vote_q;
    logic [PH_W-1:0]       phase_q;

    cdr_vote_acc #(.THR_W(THR_W)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .early   (early),
        .late    (late),
        .thr     (thr_q),
        .step_up (step_up),
        .step_dn (step_dn),
        .vote_q  (vote_q)
    );

    cdr_thr_ctrl #(.THR_W(THR_W)) u_thr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .step        (step_up || step_dn),
        .cfg_max_thr (cfg_max_thr),
        .thr_q       (thr_q),
        .locked      (locked)
    );

    cdr_phase_acc #(.PH_W(PH_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .cfg_step   (cfg_step),
        .cfg_offset (cfg_offset),
        .phase_q    (phase_q),
        .phase_out  (phase_out),
        .step_evt   (step_evt),
        .step_dir   (step_dir)
    );

endmodule

// File: rtl/cdr_vote_loop_chk.sv
module cdr_vote_loop_chk #(
    parameter int unsigned PH_W  = 8,
    parameter int unsigned THR_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  restart,
    input logic                  early,
    input logic                  late,
    input logic [PH_W-1:0]       cfg_step,
    input logic [THR_W-1:0]      cfg_max_thr,
    input logic                  step_evt,
    input logic                  step_dir,
    input logic                  locked,
    input logic [THR_W-1:0]      thr_q,
    input logic signed [THR_W:0] vote_q,
    input logic [PH_W-1:0]       phase_q
);

    logic [THR_W-1:0] ceil_chk;
    always_comb ceil_chk = (cfg_max_thr < THR_W'(2)) ? THR_W'(2) : cfg_max_thr;

    // R1: vote magnitude stays within the threshold
    a_r1_vote_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_q <= $signed({1'b0, thr_q})) && (vote_q >= -$signed({1'b0, thr_q})));

    // R2, R7: the phase moves by one step in the reported direction
    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && step_dir) |-> phase_q == PH_W'($past(phase_q) + $past(cfg_step)));
    a_r2_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && !step_dir) |-> phase_q == PH_W'($past(phase_q) - $past(cfg_step)));

    // R3: both pulses together leave the vote alone
    a_r3_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (early && late && !restart) |=> (vote_q == $past(vote_q)) && !step_evt);

    // R4: the threshold rises by one on a step below the ceiling
    a_r4_thr_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (step_evt && !$past(restart) && ($past(thr_q) < $past(ceil_chk)))
        |-> thr_q == THR_W'($past(thr_q) + THR_W'(1)));

    // R5: lock rises only after the ceiling is reached
    a_r5_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(thr_q) >= $past(ceil_chk));

    // R8: restart clears vote, threshold, lock and keeps the phase
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (vote_q == '0) && (thr_q == THR_W'(2)) && !locked
                    && !step_evt && $stable(phase_q));

endmodule

bind cdr_vote_loop cdr_vote_loop_chk #(.PH_W(PH_W), .THR_W(THR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .early       (early),
    .late        (late),
    .cfg_step    (cfg_step),
    .cfg_max_thr (cfg_max_thr),
    .step_evt    (step_evt),
    .step_dir    (step_dir),
    .locked      (locked),
    .thr_q       (thr_q),
    .vote_q      (vote_q),
    .phase_q     (phase_q)
);

// File: tb/cdr_vote_loop_tb_top.sv
`timescale 1ns/1ps
module cdr_vote_loop_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       early = 1'b0;
    logic       late = 1'b0;
    logic [7:0] cfg_step = 8'd2;
    logic [4:0] cfg_max_thr = 5'd4;
    logic [7:0] cfg_offset = 8'd0;
    logic [7:0] phase_out;
    logic       step_evt;
    logic       step_dir;
    logic       locked;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    cdr_vote_loop dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .early       (early),
        .late        (late),
        .cfg_step    (cfg_step),
        .cfg_max_thr (cfg_max_thr),
        .cfg_offset  (cfg_offset),
        .phase_out   (phase_out),
        .step_evt    (step_evt),
        .step_dir    (step_dir),
        .locked      (locked)
    );

    // Vector: {early, late, expected step_evt, expected locked, expected phase}
    // Step 2 counts, ceiling 4, offset 0, starting from reset.
    localparam logic [11:0] VEC [18] = '{
        12'h800, 12'h800, 12'hA02, 12'h402, 12'hC02, 12'h402,
        12'h402, 12'h600, 12'h500, 12'h500, 12'h500, 12'h500,
        12'h7FE, 12'h9FE, 12'h9FE, 12'h9FE, 12'h9FE, 12'hB00
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one cycle of pulses, then sample after the edge.
    task automatic pulse(input logic e, input logic l);
        early = e;
        late  = l;
        @(posedge clk);
        #1;
        early = 1'b0;
        late  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset phase", int'(phase_out), 0);
        check("R9 reset locked", int'(locked), 0);
        check("R9 reset step_evt", int'(step_evt), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R7 table walk
        for (int i = 0; i < 18; i++) begin
            pulse(VEC[i][11], VEC[i][10]);
            check($sformatf("R1 R3 step_evt vec %0d", i), int'(step_evt), int'(VEC[i][9]));
            check($sformatf("R5 locked vec %0d", i), int'(locked), int'(VEC[i][8]));
            check($sformatf("R2 phase vec %0d", i), int'(phase_out), int'(VEC[i][7:0]));
            if (VEC[i][9])
                check($sformatf("R7 step_dir vec %0d", i), int'(step_dir), int'(VEC[i][11]));
        end

        // R6 offset is added in the same cycle
        cfg_offset = 8'd32;
        #1;
        check("R6 offset 1/8", int'(phase_out), 32);
        cfg_offset = 8'd0;

        // R8 restart: vote 3 at threshold 4 is discarded, threshold back to 2
        cfg_step = 8'd4;
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        check("R1 no step at vote 3 thr 4", int'(step_evt), 0);
        restart = 1'b1;
        @(posedge clk);
        #1;
        restart = 1'b0;
        check("R8 restart clears locked", int'(locked), 0);
        check("R8 restart no step", int'(step_evt), 0);
        pulse(1'b1, 1'b0);
        check("R8 vote cleared by restart", int'(step_evt), 0);
        pulse(1'b1, 1'b0);
        check("R4 threshold 2 after restart", int'(step_evt), 0);
        pulse(1'b1, 1'b0);
        check("R4 step at vote 3", int'(step_evt), 1);
        check("R2 step of 1/64", int'(phase_out), 4);
        restart = 1'b1;
        @(posedge clk);
        #1;
        restart = 1'b0;
        check("R8 restart keeps phase", int'(phase_out), 4);

        // R6 offset wraps modulo one symbol
        cfg_offset = 8'd254;
        #1;
        check("R6 offset wrap", int'(phase_out), 2);
        cfg_offset = 8'd0;

        // R9 reset in mid-run
        rst_n = 1'b0;
        cfg_max_thr = 5'd0;
        @(posedge clk);
        #1;
        check("R9 reset clears phase", int'(phase_out), 0);
        check("R9 reset clears locked", int'(locked), 0);
        rst_n = 1'b1;

        // R4 ceiling below 2 acts as 2: each step needs three pulses
        for (int k = 0; k < 2; k++) begin
            pulse(1'b1, 1'b0);
            pulse(1'b1, 1'b0);
            check("R4 clamp no early step", int'(step_evt), 0);
            pulse(1'b1, 1'b0);
            check("R4 clamp step at third", int'(step_evt), 1);
        end
        check("R2 phase after two clamped steps", int'(phase_out), 8);
        check("R5 locked with ceiling 2", int'(locked), 1);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule